// File: doc/BRIEF.md
# Sparse Row Accumulator with Associative Merge

This block builds one row of a sparse matrix product from a stream of partial products. Each input element carries a column index for the result row and two operand values. The block combines the two operands into a contribution. It then searches every stored index at once. A matching entry is updated in place. An index that is not yet stored gets a new entry in the next free slot. Because the whole search finishes in one cycle, the block takes one element per cycle with no sorting and no multiway merge.

A per-element mode input selects the algebra. Plus-times multiplies the operands and adds the product to the stored value. Min-plus adds the operands with saturation and keeps the smaller of the stored and new values, which is the form used by shortest-path kernels. When the row is complete, a drain command streams the stored (index, value) pairs out in slot order and leaves the store empty for the next row. A clear input discards the whole row in one cycle.

The controller has two states. ST_ACCUM accepts elements. ST_DRAIN streams entries out. Three transitions connect them. START_DRAIN goes from ST_ACCUM to ST_DRAIN when a drain request arrives, the pipeline stage is empty and the store holds at least one entry. END_DRAIN goes from ST_DRAIN back to ST_ACCUM on the cycle that outputs the final entry. CLEAR forces ST_ACCUM from either state.

Top module: `sparse_row_acc`

## Requirements
- R1: The contribution of an element depends on `mode`. With mode 0 it is the low VAL_W bits of a*b. With mode 1 it is a+b, saturated to all ones.
- R2: When the element's index matches a stored index, the stored value is replaced. With mode 0 the new value is stored+contribution modulo 2^VAL_W. With mode 1 it is the minimum of the stored value and the contribution.
- R3: An element whose index is not stored takes the lowest free slot and holds its contribution. Slot order therefore equals the order in which each index first appeared, and no index is ever stored twice.
- R4: While the block is accumulating and not stalled, it accepts one element per cycle. Back-to-back elements with the same index are all merged.
- R5: When the store is full and the element in the pipeline stage misses, `overflow` goes high and `in_ready` goes low. The element is held and the condition persists until `clear`.
- R6: `clear` empties the store in one cycle and drops any held element. On the next cycle `overflow` is low and `in_ready` is high.
- R7: START_DRAIN is taken after `drain_req` is seen in ST_ACCUM with an empty pipeline stage and a non-empty store. The entries then come out on the following cycles in slot order, one per cycle. `out_last` is high only on the final entry. After that the store is empty and the block accepts input again.
- R8: `in_ready` is low for the whole of ST_DRAIN.
- R9: `drain_req` with an empty store produces no output and the block stays in ST_ACCUM.
- R10: After reset `in_ready` is high, `out_valid` is low and `overflow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Discard the row in progress |
| mode | input | 1 | 0 selects plus-times, 1 selects min-plus; sampled with each element |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Element accepted this cycle when in_valid is also high |
| in_idx | input | IDX_W | Result column index |
| in_a | input | VAL_W | First operand |
| in_b | input | VAL_W | Second operand |
| drain_req | input | 1 | Request to stream the row out |
| out_valid | output | 1 | Drained entry present |
| out_idx | output | IDX_W | Index of the drained entry |
| out_val | output | VAL_W | Accumulated value of the drained entry |
| out_last | output | 1 | Final entry of the row |
| overflow | output | 1 | Store full and a new index is waiting |

## Verification
Any fault in the key compare, the encoder or the free-slot count shows up during the drain. A duplicated index, a lost merge or an entry in the wrong slot changes the sequence of drained pairs in the very next drain. A wrong stored value appears on `out_val` in the cycle its slot is streamed. A fault in the full or stall logic is visible on `overflow` and `in_ready` in the cycle after the offending element enters the pipeline stage. A fault in the controller appears as a missing or early `out_last`, or as `in_ready` being high during a drain.

// File: rtl/sra_pkg.sv
package sra_pkg;
    typedef enum logic {
        ST_ACCUM = 1'b0,
        ST_DRAIN = 1'b1
    } sra_state_t;

    typedef enum logic {
        RING_PLUS_TIMES = 1'b0,
        RING_MIN_PLUS   = 1'b1
    } sra_ring_t;
endpackage

// File: rtl/sra_ring_ops.sv
module sra_ring_ops
    import sra_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  sra_ring_t          ring_c,
    input  logic [VAL_W-1:0]   op_a,
    input  logic [VAL_W-1:0]   op_b,
    output logic [VAL_W-1:0]   contrib,
    input  sra_ring_t          ring_m,
    input  logic [VAL_W-1:0]   acc_old,
    input  logic [VAL_W-1:0]   acc_add,
    output logic [VAL_W-1:0]   acc_new
);
    logic [VAL_W:0] sum_wide;

    // Combine step (stage 1)
    always_comb begin
        sum_wide = {1'b0, op_a} + {1'b0, op_b};
        unique case (ring_c)
            RING_PLUS_TIMES: contrib = VAL_W'(op_a * op_b);
            RING_MIN_PLUS:   contrib = sum_wide[VAL_W] ? '1 : sum_wide[VAL_W-1:0];
        endcase
    end

    // Accumulate step (stage 2)
    always_comb begin
        unique case (ring_m)
            RING_PLUS_TIMES: acc_new = acc_old + acc_add;
            RING_MIN_PLUS:   acc_new = (acc_add < acc_old) ? acc_add : acc_old;
        endcase
    end
endmodule

// File: rtl/sra_match.sv
module sra_match #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 8,
    parameter int SLOT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     keys [DEPTH],
    input  logic [DEPTH-1:0]     key_valid,
    input  logic [IDX_W-1:0]     search,
    output logic                 hit,
    output logic [SLOT_W-1:0]    hit_slot
);
    logic [DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = key_valid[g] && (keys[g] == search);
    end

    always_comb begin
        hit_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_slot = SLOT_W'(i);
        end
    end

    assign hit = |hit_vec;

    // R3
    unique_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/sparse_row_acc.sv
module sparse_row_acc
    import sra_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 16,
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               mode,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [IDX_W-1:0]   in_idx,
    input  logic [VAL_W-1:0]   in_a,
    input  logic [VAL_W-1:0]   in_b,
    input  logic               drain_req,
    output logic               out_valid,
    output logic [IDX_W-1:0]   out_idx,
    output logic [VAL_W-1:0]   out_val,
    output logic               out_last,
    output logic               overflow
);
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    sra_state_t          state_q, state_d;
    logic [IDX_W-1:0]    key_q  [DEPTH];
    logic [VAL_W-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0]    valid_q;
    logic [CNT_W-1:0]    count_q;
    logic [SLOT_W-1:0]   drain_ptr;

    logic                s1_valid;
    logic [IDX_W-1:0]    s1_idx;
    logic [VAL_W-1:0]    s1_val;
    sra_ring_t           s1_ring;

    logic                hit;
    logic [SLOT_W-1:0]   hit_slot;
    logic [VAL_W-1:0]    contrib, merged;
    logic                store_full, stall, drain_go, accept, merge_en;
    logic [SLOT_W-1:0]   free_slot;

    sra_ring_ops #(.VAL_W(VAL_W)) u_ops (
        .ring_c  (sra_ring_t'(mode)),
        .op_a    (in_a),
        .op_b    (in_b),
        .contrib (contrib),
        .ring_m  (s1_ring),
        .acc_old (data_q[hit_slot]),
        .acc_add (s1_val),
        .acc_new (merged)
    );

    sra_match #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .keys      (key_q),
        .key_valid (valid_q),
        .search    (s1_idx),
        .hit       (hit),
        .hit_slot  (hit_slot)
    );

    // Control and outputs
    always_comb begin
        store_full = (count_q == CNT_W'(DEPTH));
        free_slot  = SLOT_W'(count_q);
        stall      = s1_valid && !hit && store_full;
        drain_go   = (state_q == ST_ACCUM) && drain_req && !s1_valid && (count_q != '0);
        in_ready   = (state_q == ST_ACCUM) && !drain_go && !stall;
        accept     = in_valid && in_ready;
        merge_en   = (state_q == ST_ACCUM) && s1_valid && !stall;
        overflow   = stall;
        out_valid  = (state_q == ST_DRAIN);
        out_idx    = key_q[drain_ptr];
        out_val    = data_q[drain_ptr];
        out_last   = (state_q == ST_DRAIN) && (CNT_W'(drain_ptr) + CNT_W'(1) == count_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM: if (drain_go) state_d = ST_DRAIN;   // START_DRAIN
            ST_DRAIN: if (out_last) state_d = ST_ACCUM;   // END_DRAIN
        endcase
        if (clear) state_d = ST_ACCUM;                     // CLEAR
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACCUM;
        else        state_q <= state_d;
    end

    // Stage 1: combine register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_val   <= '0;
            s1_ring  <= RING_PLUS_TIMES;
        end else if (clear) begin
            s1_valid <= 1'b0;
        end else if (accept) begin
            s1_valid <= 1'b1;
            s1_idx   <= in_idx;
            s1_val   <= contrib;
            s1_ring  <= sra_ring_t'(mode);
        end else if (merge_en) begin
            s1_valid <= 1'b0;
        end
    end

    // Stage 2: occupancy and drain pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= '0;
            count_q   <= '0;
            drain_ptr <= '0;
        end else if (clear || out_last) begin
            valid_q   <= '0;
            count_q   <= '0;
            drain_ptr <= '0;
        end else begin
            if (merge_en && !hit) begin
                valid_q[free_slot] <= 1'b1;
                count_q            <= count_q + CNT_W'(1);
            end
            if (state_q == ST_DRAIN) drain_ptr <= drain_ptr + SLOT_W'(1);
            else                     drain_ptr <= '0;
        end
    end

    // Stage 2: key and data arrays
    always_ff @(posedge clk) begin
        if (merge_en && !clear) begin
            if (hit) begin
                data_q[hit_slot] <= merged;
            end else begin
                key_q[free_slot]  <= s1_idx;
                data_q[free_slot] <= s1_val;
            end
        end
    end

    // R5
    overflow_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !in_ready);
    // R5
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> (overflow && $stable(s1_idx)));
    // R6
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0 && !overflow && !out_valid));
    // R7
    last_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R7
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (count_q == '0 && !out_valid));
    // R8
    drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
endmodule

// File: tb/sparse_row_acc_bench.sv
`timescale 1ns/1ps
module sparse_row_acc_bench;
    localparam int IDX_W = 8;
    localparam int VAL_W = 16;
    localparam int DEPTH = 8;
    localparam int NVEC  = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0, mode = 1'b0, in_valid = 1'b0, drain_req = 1'b0;
    logic [IDX_W-1:0] in_idx = '0;
    logic [VAL_W-1:0] in_a = '0, in_b = '0;
    logic in_ready, out_valid, out_last, overflow;
    logic [IDX_W-1:0] out_idx;
    logic [VAL_W-1:0] out_val;

    int tests = 0;
    int fails = 0;
    int ref_val [int];
    int ref_order [$];

    // {end_of_batch, mode, idx, a, b}
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'd5,  16'd3,      16'd4},
        {1'b0, 1'b0, 8'd2,  16'd2,      16'd10},
        {1'b0, 1'b0, 8'd5,  16'd1,      16'd1},
        {1'b0, 1'b0, 8'd5,  16'd2,      16'd2},
        {1'b0, 1'b0, 8'd9,  16'h0100,   16'h0100},
        {1'b1, 1'b0, 8'd2,  16'hFFFF,   16'd1},
        {1'b0, 1'b1, 8'd7,  16'd10,     16'd5},
        {1'b0, 1'b1, 8'd7,  16'd3,      16'd4},
        {1'b0, 1'b1, 8'd3,  16'hFFF0,   16'h0100},
        {1'b0, 1'b1, 8'd7,  16'd20,     16'd1},
        {1'b1, 1'b1, 8'd3,  16'd1,      16'd2}
    };

    sparse_row_acc #(.IDX_W(IDX_W), .VAL_W(VAL_W), .DEPTH(DEPTH)) u_sparse_row_acc (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
        .in_a(in_a), .in_b(in_b), .drain_req(drain_req),
        .out_valid(out_valid), .out_idx(out_idx), .out_val(out_val),
        .out_last(out_last), .overflow(overflow)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int contrib_of(input bit m, input int a, input int b);
        if (!m) return (a * b) & 32'hFFFF;
        return (a + b > 32'hFFFF) ? 32'hFFFF : a + b;
    endfunction

    task automatic ref_add(input bit m, input int idx, input int a, input int b);
        int c;
        c = contrib_of(m, a, b);
        if (ref_val.exists(idx)) begin
            if (!m) ref_val[idx] = (ref_val[idx] + c) & 32'hFFFF;
            else if (c < ref_val[idx]) ref_val[idx] = c;
        end else begin
            ref_val[idx] = c;
            ref_order.push_back(idx);
        end
    endtask

    task automatic send(input bit m, input int idx, input int a, input int b);
        @(negedge clk);
        in_valid = 1'b1; mode = m;
        in_idx = IDX_W'(idx); in_a = VAL_W'(a); in_b = VAL_W'(b);
        @(posedge clk);
    endtask

    // R7 R2 R3: drain and compare against reference
    task automatic drain_and_check();
        int n;
        n = ref_order.size();
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk); drain_req = 1'b1;
        @(posedge clk);
        @(negedge clk); drain_req = 1'b0;
        for (int k = 0; k < n; k++) begin
            check(out_valid && out_idx == IDX_W'(ref_order[k]) &&
                  out_val == VAL_W'(ref_val[ref_order[k]]) && out_last == (k == n - 1),
                  "R2/R3/R7 drained entry", {out_last, out_valid, out_idx, out_val},
                  {(k == n - 1), 1'b1, IDX_W'(ref_order[k]), VAL_W'(ref_val[ref_order[k]])});
            check(!in_ready, "R8 ready low in drain", in_ready, 0);
            @(posedge clk);
            @(negedge clk);
        end
        check(!out_valid && in_ready, "R7 drain done, accepting", {out_valid, in_ready}, 1);
        ref_val.delete();
        ref_order.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R10
        check(in_ready == 1'b1, "R10 reset ready", in_ready, 1);
        check(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
        check(overflow == 1'b0, "R10 reset overflow", overflow, 0);

        // R1 R2 R3 R4: table walk, back-to-back elements every cycle
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][40], int'(VEC[i][39:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]));
            ref_add(VEC[i][40], int'(VEC[i][39:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]));
            if (VEC[i][41]) drain_and_check();
        end

        // R5: fill the store, then one more new index
        for (int j = 0; j < DEPTH; j++) send(1'b0, 20 + j, 1, 1);
        send(1'b0, 40, 1, 1);
        @(negedge clk); in_valid = 1'b0;
        check(overflow == 1'b1, "R5 overflow raised", overflow, 1);
        check(in_ready == 1'b0, "R5 ready dropped", in_ready, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(overflow == 1'b1 && in_ready == 1'b0, "R5 overflow persists",
              {overflow, in_ready}, 2);

        // R6: clear
        clear = 1'b1;
        @(posedge clk);
        @(negedge clk); clear = 1'b0;
        check(overflow == 1'b0 && in_ready == 1'b1, "R6 clear recovers",
              {overflow, in_ready}, 1);

        // R9: drain on empty store
        drain_req = 1'b1;
        @(posedge clk);
        @(negedge clk); drain_req = 1'b0;
        check(out_valid == 1'b0, "R9 empty drain no output", out_valid, 0);
        check(in_ready == 1'b1, "R9 still accepting", in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 empty drain later", out_valid, 0);

        // R6: store empty after clear, fresh row starts at slot 0
        send(1'b0, 1, 2, 3);
        ref_add(1'b0, 1, 2, 3);
        drain_and_check();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule